// File: doc/BRIEF.md
# Bus Safety Reaction Timing Checker

This block is a passive, synthesizable monitor placed on the memory-mapped target port of a processing unit. It decodes the traffic on that port and watches for the moment software learns of a checksum fault. That moment is a completed read of the unit's status register that returns the fault bit set. From then on the monitor requires two things of the next access to the unit. It must be a write to the unit's command register that clears the enable bit. It must also be issued no more than a configured number of clock cycles after the fault was seen.

A breach of either rule is latched in one of two flags. The flags stay set until reset, and each one raises a one-cycle interrupt pulse the first time it sets. Every new fault observation restarts the elapsed-time count, so a fault seen again while a reaction is still pending starts a fresh window. The monitor drives nothing on the bus. It needs one cycle or more of read latency, and read responses must return in order.

Top module: `safety_react_mon`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `viol_order`, `viol_timeout` and `irq` are all low.
- R2: A fault event is a read response whose oldest outstanding read was to STATUS (offset 0x04 inside the unit window) and whose data has bit 1 set. A STATUS response with bit 1 clear is not a fault event. A response to any other read is not a fault event, whatever its data.
- R3: A write to COMMAND (offset 0x00) with data bit 0 clear is a deactivation. When it is the first unit access after a fault event and is issued n cycles after that event, with 1 ≤ n ≤ limit, neither flag sets.
- R4: If the first unit access after a fault event is not a deactivation (for example any read, or a COMMAND write with bit 0 set), `viol_order` is high from the cycle after that access.
- R5: The unit window is the set of addresses where (addr & 0xFF00) == 0x4000. A request counts as an access only when valid and ready are both high. Requests outside the window, and requests without ready, are ignored.
- R6: If no unit access is issued within limit cycles of a fault event, `viol_timeout` rises in the cycle after cycle limit+1. An access issued in cycle limit+1 is judged late, not out of order.
- R7: A fault event that arrives while a reaction is pending restarts the count from that event.
- R8: Both flags stay set until reset, and checking goes on after a flag has set.
- R9: `irq` is high for exactly one cycle, in the first cycle that a flag reads high. A repeat breach of a flag that is already set does not pulse it.
- R10: The limit is read from `cfg_limit` every cycle. It covers 0 to 4095: a limit of 0 makes every fault time out, and a limit of 4095 still accepts a deactivation issued 4095 cycles after the fault.
- R11: After a fault has been settled by a deactivation, a breach or a timeout, later accesses and idle time raise no flag until the next fault event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_limit | input | 12 | Reaction limit in clock cycles |
| bus_req_valid | input | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted by the target |
| bus_req_write | input | 1 | 1 = write, 0 = read |
| bus_req_addr | input | 16 | Request address |
| bus_req_wdata | input | 32 | Write data |
| bus_rsp_valid | input | 1 | Read response valid (in order) |
| bus_rsp_rdata | input | 32 | Read response data |
| viol_order | output | 1 | Sticky: the first access after a fault was not a deactivation |
| viol_timeout | output | 1 | Sticky: the reaction limit expired |
| irq | output | 1 | One-cycle pulse when a flag first sets |

## Verification
The assertions take the bus as well formed. Every read response belongs to an earlier accepted read, responses return in issue order, no more reads are outstanding than the tracking depth allows, and no response comes in the same cycle as its own request. The stimulus respects all of this. It gives every read exactly one response, one cycle or more later, and never lets two reads go past the depth. Constrained-random traffic then mixes unit reads and writes, out-of-window accesses, stalled requests, fault and non-fault status data, random gaps and random limits. Directed cases cover the exact limit boundary, reload on a repeated fault, and the extreme limits.

// File: rtl/srm_pkg.sv
`timescale 1ns/1ps
package srm_pkg;

   // One decoded request, as seen by the checker
   typedef struct packed {
      logic hit;        // address lies in the unit window
      logic is_read;    // read request (any address)
      logic status_rd;  // read of the status register
      logic deact;      // command write clearing the enable bit
   } dec_t;

endpackage

// File: rtl/srm_decode.sv
`timescale 1ns/1ps
module srm_decode
   import srm_pkg::*;
#(
   parameter int unsigned         ADDR_W      = 16,
   parameter logic [ADDR_W-1:0]   UNIT_BASE   = 16'h4000,
   parameter logic [ADDR_W-1:0]   UNIT_MASK   = 16'hFF00,
   parameter logic [ADDR_W-1:0]   STATUS_OFS  = 16'h0004,
   parameter logic [ADDR_W-1:0]   COMMAND_OFS = 16'h0000
) (
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              en_bit,
   output dec_t              dec_o
);

   localparam logic [ADDR_W-1:0] OFS_MASK = ~UNIT_MASK;

   if ((STATUS_OFS & UNIT_MASK) != '0 || (COMMAND_OFS & UNIT_MASK) != '0) begin : g_bad_ofs
      $error("register offsets must lie inside the unit window");
   end
   if (STATUS_OFS == COMMAND_OFS) begin : g_same_ofs
      $error("status and command offsets must differ");
   end

   logic              in_win;
   logic [ADDR_W-1:0] ofs;

   always_comb begin
      in_win          = (req_addr & UNIT_MASK) == (UNIT_BASE & UNIT_MASK);
      ofs             = req_addr & OFS_MASK;
      dec_o.hit       = in_win;
      dec_o.is_read   = !req_write;
      dec_o.status_rd = in_win && !req_write && (ofs == STATUS_OFS);
      dec_o.deact     = in_win && req_write && (ofs == COMMAND_OFS) && !en_bit;
   end

endmodule

// File: rtl/srm_rdtrack.sv
`timescale 1ns/1ps
module srm_rdtrack #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_stat,
   input  logic pop,
   output logic head_stat,
   output logic empty
);

   if (DEPTH == 0 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end

   logic full;
   logic do_pop;
   assign do_pop = pop && !empty;

   if (DEPTH == 1) begin : g_single
      logic stat_q;
      logic vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            if (push) begin
               vld_q  <= 1'b1;
               stat_q <= push_stat;
            end else if (do_pop) begin
               vld_q  <= 1'b0;
            end
         end
      end
      assign head_stat = stat_q;
      assign empty     = !vld_q;
      assign full      = vld_q;
   end else begin : g_ring
      localparam int unsigned PTR_W = $clog2(DEPTH);
      logic [DEPTH-1:0] slot_q;
      logic [PTR_W-1:0] wp_q, rp_q;
      logic [PTR_W:0]   cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
         end else begin
            if (push) begin
               slot_q[wp_q] <= push_stat;
               wp_q         <= wp_q + 1'b1;
            end
            if (do_pop) rp_q <= rp_q + 1'b1;
            if (push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (!push && do_pop) cnt_q <= cnt_q - 1'b1;
         end
      end
      assign head_stat = slot_q[rp_q];
      assign empty     = (cnt_q == '0);
      assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
   end

   // R2: responses only for reads that are outstanding
   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R2: the tracking depth is never exceeded
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);

endmodule

// File: rtl/srm_timer.sv
`timescale 1ns/1ps
module srm_timer #(
   parameter int unsigned LIMIT_W = 12,
   parameter int unsigned CNT_W   = LIMIT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               run,
   input  logic [LIMIT_W-1:0] limit,
   output logic               over
);

   if (CNT_W <= LIMIT_W) begin : g_bad_w
      $error("counter must be wider than the limit");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] elapsed_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                           elapsed_q <= '0;
      else if (load)                        elapsed_q <= CNT_ONE;
      else if (run && elapsed_q != CNT_MAX) elapsed_q <= elapsed_q + 1'b1;
   end

   assign over = elapsed_q > {{(CNT_W-LIMIT_W){1'b0}}, limit};

   // R7: every fault observation restarts the count
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> elapsed_q == CNT_ONE);
   // R10: the count saturates instead of wrapping
   a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> elapsed_q >= $past(elapsed_q));

endmodule

// File: rtl/safety_react_mon.sv
`timescale 1ns/1ps
module safety_react_mon
   import srm_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 16,
   parameter int unsigned       DATA_W       = 32,
   parameter int unsigned       LIMIT_W      = 12,
   parameter int unsigned       LIMIT_SRC    = 1,     // 1: cfg_limit port, 0: LIMIT_CYCLES
   parameter int unsigned       LIMIT_CYCLES = 100,
   parameter int unsigned       RD_DEPTH     = 4,
   parameter int unsigned       ERR_BIT      = 1,
   parameter int unsigned       EN_BIT       = 0,
   parameter logic [ADDR_W-1:0] UNIT_BASE    = 16'h4000,
   parameter logic [ADDR_W-1:0] UNIT_MASK    = 16'hFF00,
   parameter logic [ADDR_W-1:0] STATUS_OFS   = 16'h0004,
   parameter logic [ADDR_W-1:0] COMMAND_OFS  = 16'h0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LIMIT_W-1:0] cfg_limit,
   input  logic               bus_req_valid,
   input  logic               bus_req_ready,
   input  logic               bus_req_write,
   input  logic [ADDR_W-1:0]  bus_req_addr,
   input  logic [DATA_W-1:0]  bus_req_wdata,
   input  logic               bus_rsp_valid,
   input  logic [DATA_W-1:0]  bus_rsp_rdata,
   output logic               viol_order,
   output logic               viol_timeout,
   output logic               irq
);

   localparam int unsigned CNT_W = LIMIT_W + 1;

   if (ERR_BIT >= DATA_W || EN_BIT >= DATA_W) begin : g_bad_bit
      $error("flag bit positions must lie inside the data word");
   end
   if (LIMIT_W < 1 || LIMIT_W > 30) begin : g_bad_lw
      $error("LIMIT_W out of range");
   end
   if (LIMIT_SRC > 1) begin : g_bad_src
      $error("LIMIT_SRC must be 0 or 1");
   end
   if (LIMIT_CYCLES >= (1 << LIMIT_W)) begin : g_bad_lim
      $error("LIMIT_CYCLES does not fit LIMIT_W");
   end

   dec_t               dec;
   logic               req_fire, acc_fire;
   logic               head_stat, rd_empty;
   logic               err_ev;
   logic [LIMIT_W-1:0] lim_eff;
   logic               over;
   logic               armed_q;
   logic               late, bad_order, settled;

   // bits of the data buses that the checker does not look at
   logic unused_ok;
   assign unused_ok = ^{bus_req_wdata, bus_rsp_rdata, cfg_limit};

   if (LIMIT_SRC == 1) begin : g_lim_port
      assign lim_eff = cfg_limit;
   end else begin : g_lim_param
      assign lim_eff = LIMIT_W'(LIMIT_CYCLES);
   end

   srm_decode #(
      .ADDR_W(ADDR_W), .UNIT_BASE(UNIT_BASE), .UNIT_MASK(UNIT_MASK),
      .STATUS_OFS(STATUS_OFS), .COMMAND_OFS(COMMAND_OFS)
   ) u_dec (
      .req_write (bus_req_write),
      .req_addr  (bus_req_addr),
      .en_bit    (bus_req_wdata[EN_BIT]),
      .dec_o     (dec)
   );

   assign req_fire = bus_req_valid && bus_req_ready;
   assign acc_fire = req_fire && dec.hit;

   srm_rdtrack #(.DEPTH(RD_DEPTH)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (req_fire && dec.is_read),
      .push_stat (dec.status_rd),
      .pop       (bus_rsp_valid),
      .head_stat (head_stat),
      .empty     (rd_empty)
   );

   assign err_ev = bus_rsp_valid && !rd_empty && head_stat && bus_rsp_rdata[ERR_BIT];

   srm_timer #(.LIMIT_W(LIMIT_W), .CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (err_ev),
      .run   (armed_q),
      .limit (lim_eff),
      .over  (over)
   );

   always_comb begin
      late      = armed_q && over;
      bad_order = armed_q && !late && acc_fire && !dec.deact;
      settled   = armed_q && (late || acc_fire);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q      <= 1'b0;
         viol_order   <= 1'b0;
         viol_timeout <= 1'b0;
         irq          <= 1'b0;
      end else begin
         armed_q      <= err_ev || (armed_q && !settled);
         viol_order   <= viol_order || bad_order;
         viol_timeout <= viol_timeout || late;
         irq          <= (bad_order && !viol_order) || (late && !viol_timeout);
      end
   end

   // R8: flags are sticky
   a_r8_order_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      viol_order |=> viol_order);
   a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      viol_timeout |=> viol_timeout);
   // R9: the interrupt only accompanies a flag's first rise
   a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($rose(viol_order) || $rose(viol_timeout)));
   // R4: an ordering breach is caused by a unit access that is not a deactivation
   a_r4_order_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_order) |-> $past(acc_fire && !dec.deact));
   // R6: a timeout only follows an expired count
   a_r6_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_timeout) |-> $past(over));
   // R1: flags and pulse low right after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !viol_order && !viol_timeout && !irq);

endmodule

// File: tb/sim_safety_react_mon.sv
`timescale 1ns/1ps
module sim_safety_react_mon;

   localparam logic [15:0] A_CMD  = 16'h4000;
   localparam logic [15:0] A_STAT = 16'h4004;
   localparam logic [15:0] A_OTH  = 16'h4008;
   localparam logic [15:0] A_OUT  = 16'h5004;
   localparam int          CMAX   = 8191;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_limit = 12'd10;
   logic        bus_req_valid = 1'b0, bus_req_ready = 1'b0, bus_req_write = 1'b0;
   logic [15:0] bus_req_addr = '0;
   logic [31:0] bus_req_wdata = '0;
   logic        bus_rsp_valid = 1'b0;
   logic [31:0] bus_rsp_rdata = '0;
   logic        viol_order, viol_timeout, irq;

   always #2 clk = ~clk;

   safety_react_mon u0 (
      .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit),
      .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
      .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
      .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
      .bus_rsp_rdata(bus_rsp_rdata), .viol_order(viol_order),
      .viol_timeout(viol_timeout), .irq(irq)
   );

   int    checks = 0, fails = 0;
   bit    finished = 0;
   string cur_tag = "R1";

   // reference model state
   bit m_armed, m_ord, m_tmo, m_irq;
   int m_cnt;
   bit pq[$];

   function automatic void chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL [%s] %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endfunction

   function automatic void model_clear();
      m_armed = 0; m_ord = 0; m_tmo = 0; m_irq = 0; m_cnt = 0;
      pq.delete();
   endfunction

   // expected behaviour after one clock edge, from the requirements
   function automatic void model_step();
      bit acc, fire, deact, err, late, bad;
      fire  = bus_req_valid && bus_req_ready;
      acc   = fire && ((bus_req_addr & 16'hFF00) == 16'h4000);
      deact = acc && bus_req_write && (bus_req_addr[7:0] == 8'h00) && !bus_req_wdata[0];
      err   = 0;
      if (bus_rsp_valid && pq.size() > 0) begin
         err = pq[0] && bus_rsp_rdata[1];
         void'(pq.pop_front());
      end
      if (fire && !bus_req_write)
         pq.push_back(acc && bus_req_addr[7:0] == 8'h04);
      late  = m_armed && (m_cnt > int'(cfg_limit));
      bad   = m_armed && !late && acc && !deact;
      m_irq = (bad && !m_ord) || (late && !m_tmo);
      m_ord = m_ord || bad;
      m_tmo = m_tmo || late;
      if (err) begin
         m_armed = 1; m_cnt = 1;
      end else begin
         if (m_armed && m_cnt < CMAX) m_cnt++;
         m_armed = m_armed && !(late || acc);
      end
   endfunction

   task automatic cyc(input logic v, input logic rdy, input logic w, input logic [15:0] a,
                      input logic [31:0] d, input logic rv, input logic [31:0] rd);
      bus_req_valid = v; bus_req_ready = rdy; bus_req_write = w;
      bus_req_addr = a; bus_req_wdata = d; bus_rsp_valid = rv; bus_rsp_rdata = rd;
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(cur_tag, "viol_order", viol_order, m_ord);
      chk(cur_tag, "viol_timeout", viol_timeout, m_tmo);
      chk(cur_tag, "irq", irq, m_irq);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, '0, 0, '0);
   endtask
   task automatic rd(input logic [15:0] a);          cyc(1, 1, 0, a, '0, 0, '0); endtask
   task automatic rsp(input logic [31:0] d);         cyc(0, 0, 0, '0, '0, 1, d); endtask
   task automatic wr(input logic [15:0] a, input logic [31:0] d); cyc(1, 1, 1, a, d, 0, '0); endtask
   task automatic fault(); rd(A_STAT); rsp(32'h2); endtask

   task automatic do_reset(input logic [11:0] lim);
      rst_n = 0; cfg_limit = lim;
      bus_req_valid = 0; bus_req_ready = 0; bus_req_write = 0;
      bus_req_addr = '0; bus_req_wdata = '0; bus_rsp_valid = 0; bus_rsp_rdata = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1", "viol_order in reset", viol_order, 1'b0);
      chk("R1", "irq in reset", irq, 1'b0);
      rst_n = 1;
      model_clear();
   endtask

   task automatic flags(input string tag, input logic o, input logic t);
      chk(tag, "viol_order", viol_order, o);
      chk(tag, "viol_timeout", viol_timeout, t);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL [R1] watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20111));
      @(negedge clk);

      // R1
      do_reset(12'd10); cur_tag = "R1"; idle(1); flags("R1", 0, 0);
      chk("R1", "irq after reset", irq, 1'b0);

      // R3 and R11: deactivation in time, then quiet
      cur_tag = "R3"; fault(); idle(4); wr(A_CMD, 32'h0); flags("R3", 0, 0);
      cur_tag = "R11"; idle(15); rd(A_OTH); rsp(32'h0); wr(A_CMD, 32'h1); flags("R11", 0, 0);

      // R4 and R9: a read after the fault; the COMMAND response with bit 1 must not arm (R2)
      do_reset(12'd10); cur_tag = "R4"; fault(); rd(A_CMD);
      flags("R4", 1, 0); chk("R9", "irq on first rise", irq, 1'b1);
      rsp(32'h2); chk("R9", "irq one cycle", irq, 1'b0);
      cur_tag = "R2"; idle(14); flags("R2", 1, 0);

      // R4: COMMAND write keeping the enable bit set
      do_reset(12'd10); cur_tag = "R4"; fault(); idle(2); wr(A_CMD, 32'h1); flags("R4", 1, 0);

      // R2: non-fault data and non-status reads
      do_reset(12'd10); cur_tag = "R2"; rd(A_STAT); rsp(32'hFFFF_FFFD);
      rd(A_OTH); rsp(32'h2); rd(A_OUT); rsp(32'h2); idle(20); flags("R2", 0, 0);

      // R5: ignored traffic, then a valid deactivation
      do_reset(12'd10); cur_tag = "R5"; fault();
      wr(A_OUT, 32'h1); cyc(1, 0, 1, A_CMD, 32'h1, 0, '0); cyc(1, 0, 0, A_STAT, '0, 0, '0);
      rd(A_OUT); rsp(32'h2); wr(A_CMD, 32'h0); flags("R5", 0, 0);

      // R6: exact expiry
      do_reset(12'd5); cur_tag = "R6"; fault(); idle(5); flags("R6", 0, 0);
      idle(1); flags("R6", 0, 1); chk("R9", "irq on timeout", irq, 1'b1);

      // R3: deactivation exactly at the limit
      do_reset(12'd5); cur_tag = "R3"; fault(); idle(4); wr(A_CMD, 32'h0); idle(8); flags("R3", 0, 0);

      // R6: deactivation one cycle late is a timeout, not an ordering breach
      do_reset(12'd5); cur_tag = "R6"; fault(); idle(5); wr(A_CMD, 32'h0); flags("R6", 0, 1);

      // R7: a second fault restarts the count
      do_reset(12'd6); cur_tag = "R7"; rd(A_STAT); rd(A_STAT); rsp(32'h2); idle(4);
      rsp(32'h2); idle(5); wr(A_CMD, 32'h0); flags("R7", 0, 0);

      // R8 and R9: repeat breach keeps the flag but gives no pulse
      do_reset(12'd4); cur_tag = "R8"; fault(); wr(A_CMD, 32'h1); flags("R8", 1, 0);
      fault(); wr(A_CMD, 32'h1); flags("R8", 1, 0); chk("R9", "no pulse on repeat", irq, 1'b0);
      fault(); idle(5); flags("R8", 1, 1); chk("R9", "pulse on second flag", irq, 1'b1);
      do_reset(12'd4); idle(1); flags("R8", 0, 0);

      // R10: extreme limits
      do_reset(12'd0); cur_tag = "R10"; fault(); wr(A_CMD, 32'h0); flags("R10", 0, 1);
      do_reset(12'd4095); fault(); idle(4094); wr(A_CMD, 32'h0); flags("R10", 0, 0);

      // constrained random traffic, R4 R6 checked each cycle against the model
      do_reset(12'd7); cur_tag = "R4 R6";
      for (int it = 0; it < 3000; it++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0: idle(int'($urandom % 6));
            1, 2: begin
               rd(A_STAT); idle(int'($urandom % 3));
               rsp(($urandom % 2 == 0) ? 32'h2 : {$urandom} & 32'hFFFF_FFFD);
            end
            3: wr(A_CMD, ($urandom % 3 == 0) ? 32'h1 : 32'h0);
            4: begin rd(A_CMD); rsp($urandom); end
            5: begin
               if ($urandom % 2 == 0) wr(A_OUT, $urandom);
               else begin rd(A_OUT); rsp($urandom); end
            end
            6: cyc(1, 0, $urandom % 2 == 0, A_CMD, $urandom, 0, '0);
            default: begin
               if ($urandom % 8 == 0) begin
                  do_reset(12'($urandom % 12)); cur_tag = "R4 R6";
               end else idle(int'($urandom % 16));
            end
         endcase
      end

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule